// File: doc/BRIEF.md
# Page Table Entry Classifier

This block takes one 64-bit page table entry, as fetched during a multi-level address translation walk, and sorts it into one of three kinds: a malformed entry that must end the walk with a page fault, a pointer that the walker follows to the next table level, or a valid leaf that ends the walk with a mapping. It looks at the low attribute byte and at the ten extension bits from the top of the entry, and it takes three enables: whether naturally aligned power-of-two (contiguous) mappings are supported, whether page-based memory types are supported, and whether software has switched memory types on.

The block is purely combinational: the walker presents the entry and reads the three kind flags in the same cycle, together with the contiguous-mapping flag and the two-bit memory type, which it keeps for the leaf it installs. Permission checks against access type and privilege belong to a later stage and are not made here.

Top module: `pte_entry_classifier`

## Requirements
- R1: Exactly one of `bad_o`, `ptr_o` and `leaf_o` is high for any input; `ptr_o` is high only for a well-formed entry whose read, write and execute bits (attribute bits 1, 2, 3) are all zero, and `leaf_o` only for a well-formed entry with at least one of them set.
- R2: An entry whose valid bit (attribute bit 0) is zero is reported bad.
- R3: An entry with the write bit (attribute bit 2) set and the read bit (attribute bit 1) clear is reported bad.
- R4: An entry with any of extension bits 6:0 set, or with the memory-type field (extension bits 8:7) equal to 3, is reported bad.
- R5: A leaf-shaped entry (R, W or X set) with the contiguous flag (extension bit 9) set is reported bad when `napot_en_i` is low, and is accepted as a leaf when `napot_en_i` is high and no other rule fires.
- R6: A leaf-shaped entry with a nonzero memory type is reported bad when `mtype_en_i` or `mtype_on_i` is low, and is accepted when both are high and no other rule fires.
- R7: A pointer-shaped entry is reported bad when its dirty (bit 7), accessed (bit 6) or user (bit 4) attribute is set, when the contiguous flag is set, or when the memory type is nonzero, whatever the enables; the global bit (bit 5) has no effect on the kind.
- R8: `napot_o` always equals extension bit 9 and `mtype_o` always equals extension bits 8:7, whatever the kind.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| attr_i | input | 8 | Entry bits 7:0: D, A, G, U, X, W, R, V from bit 7 down to bit 0 |
| ext_i | input | 10 | Entry bits 63:54: contiguous flag at 9, memory type at 8:7, reserved at 6:0 |
| napot_en_i | input | 1 | Contiguous mappings supported |
| mtype_en_i | input | 1 | Page-based memory types supported |
| mtype_on_i | input | 1 | Software enable for page-based memory types |
| bad_o | output | 1 | Entry is malformed or invalid |
| ptr_o | output | 1 | Entry is a valid pointer to the next level |
| leaf_o | output | 1 | Entry is a valid leaf |
| napot_o | output | 1 | Contiguous flag of the entry |
| mtype_o | output | 2 | Memory-type field of the entry |

## Verification
The bench aims at the places where the pointer and leaf rules part ways: a pointer carrying the contiguous flag or a memory type with every enable high must still be bad, which a design applying the leaf rules to pointers would accept. It walks the memory-type enables one at a time, since a design that checks only the support enable and not the software switch would accept a leaf it should reject. The reserved memory-type value 3 and each single reserved bit are tried on otherwise perfect leaves, where a design with a narrowed reserved mask or a missing value check would return a leaf. Write-without-read and the global bit on pointers catch designs that misjudge attribute combinations.

// File: rtl/pte_chk_pkg.sv
package pte_chk_pkg;
  localparam int ATTR_W  = 8;
  localparam int EXT_W   = 10;
  localparam int MT_W    = 2;
  localparam int RSVD_W  = EXT_W - 1 - MT_W;
  localparam logic [MT_W-1:0] MT_RESERVED = '1;

  typedef struct packed {
    logic dirty;
    logic accessed;
    logic glb;
    logic user;
    logic exec;
    logic write;
    logic read;
    logic valid;
  } attr_t;

  typedef struct packed {
    logic              napot;
    logic [MT_W-1:0]   mtype;
    logic [RSVD_W-1:0] rsvd;
  } ext_t;

  typedef enum int {
    CAUSE_NOT_VALID = 0,
    CAUSE_W_NO_R    = 1,
    CAUSE_RSVD_SET  = 2,
    CAUSE_MT_RES    = 3,
    CAUSE_NAPOT_OFF = 4,
    CAUSE_MT_OFF    = 5,
    CAUSE_PTR_ATTR  = 6
  } cause_e;

  localparam int NUM_CAUSES = 7;
endpackage

// File: rtl/pte_field_split.sv
module pte_field_split
  import pte_chk_pkg::*;
(
  input  logic [ATTR_W-1:0] attr_raw,
  input  logic [EXT_W-1:0]  ext_raw,
  output attr_t             attr,
  output ext_t              ext,
  output logic              ptr_shape
);
  always_comb begin
    attr      = attr_t'(attr_raw);
    ext       = ext_t'(ext_raw);
    ptr_shape = ~(attr.read | attr.write | attr.exec);
  end
endmodule

// File: rtl/pte_fault_rules.sv
module pte_fault_rules
  import pte_chk_pkg::*;
(
  input  attr_t                 attr,
  input  ext_t                  ext,
  input  logic                  ptr_shape,
  input  logic                  napot_en,
  input  logic                  mtype_en,
  input  logic                  mtype_on,
  output logic [NUM_CAUSES-1:0] causes
);
  logic mt_nonzero;
  logic mt_allowed;

  always_comb begin
    mt_nonzero = |ext.mtype;
    mt_allowed = mtype_en & mtype_on;
    causes     = '0;
    causes[CAUSE_NOT_VALID] = ~attr.valid;
    causes[CAUSE_W_NO_R]    = attr.write & ~attr.read;
    causes[CAUSE_RSVD_SET]  = |ext.rsvd;
    causes[CAUSE_MT_RES]    = (ext.mtype == MT_RESERVED);
    causes[CAUSE_NAPOT_OFF] = ~ptr_shape & ext.napot & ~napot_en;
    causes[CAUSE_MT_OFF]    = ~ptr_shape & mt_nonzero & ~mt_allowed;
    causes[CAUSE_PTR_ATTR]  = ptr_shape &
                              (attr.dirty | attr.accessed | attr.user |
                               ext.napot | mt_nonzero);
  end
endmodule

// File: rtl/pte_kind_select.sv
module pte_kind_select
  import pte_chk_pkg::*;
#(
  parameter int N_IN = NUM_CAUSES
) (
  input  logic [N_IN-1:0] causes,
  input  logic            ptr_shape,
  output logic            bad,
  output logic            ptr,
  output logic            leaf
);
  logic [N_IN:0] acc;

  assign acc[0] = 1'b0;
  for (genvar g = 0; g < N_IN; g++) begin : g_or
    assign acc[g+1] = acc[g] | causes[g];
  end

  always_comb begin
    bad  = acc[N_IN];
    ptr  = ~bad & ptr_shape;
    leaf = ~bad & ~ptr_shape;
  end
endmodule

// File: rtl/pte_entry_classifier.sv
module pte_entry_classifier
  import pte_chk_pkg::*;
(
  input  logic [ATTR_W-1:0] attr_i,
  input  logic [EXT_W-1:0]  ext_i,
  input  logic              napot_en_i,
  input  logic              mtype_en_i,
  input  logic              mtype_on_i,
  output logic              bad_o,
  output logic              ptr_o,
  output logic              leaf_o,
  output logic              napot_o,
  output logic [MT_W-1:0]   mtype_o
);
  attr_t                 attr_s;
  ext_t                  ext_s;
  logic                  ptr_shape_s;
  logic [NUM_CAUSES-1:0] causes_s;

  pte_field_split u_split (
    .attr_raw  (attr_i),
    .ext_raw   (ext_i),
    .attr      (attr_s),
    .ext       (ext_s),
    .ptr_shape (ptr_shape_s)
  );

  pte_fault_rules u_rules (
    .attr      (attr_s),
    .ext       (ext_s),
    .ptr_shape (ptr_shape_s),
    .napot_en  (napot_en_i),
    .mtype_en  (mtype_en_i),
    .mtype_on  (mtype_on_i),
    .causes    (causes_s)
  );

  pte_kind_select #(.N_IN(NUM_CAUSES)) u_kind (
    .causes    (causes_s),
    .ptr_shape (ptr_shape_s),
    .bad       (bad_o),
    .ptr       (ptr_o),
    .leaf      (leaf_o)
  );

  assign napot_o = ext_s.napot;
  assign mtype_o = ext_s.mtype;
endmodule

// File: rtl/pte_entry_classifier_chk.sv
module pte_entry_classifier_chk
  import pte_chk_pkg::*;
(
  input logic [ATTR_W-1:0] attr_i,
  input logic [EXT_W-1:0]  ext_i,
  input logic              napot_en_i,
  input logic              mtype_en_i,
  input logic              mtype_on_i,
  input logic              bad_o,
  input logic              ptr_o,
  input logic              leaf_o,
  input logic              napot_o,
  input logic [MT_W-1:0]   mtype_o
);
  logic known;
  logic rwx_zero;

  always_comb begin
    known    = !$isunknown({attr_i, ext_i, napot_en_i, mtype_en_i, mtype_on_i});
    rwx_zero = (attr_i[3:1] == 3'b000);
    if (known) begin
      // R1
      one_kind_chk: assert ($countones({bad_o, ptr_o, leaf_o}) == 1);
      // R1
      ptr_shape_chk: assert (!ptr_o || rwx_zero);
      // R2
      no_valid_chk: assert (attr_i[0] || bad_o);
      // R3
      w_no_r_chk: assert (!(attr_i[2] && !attr_i[1]) || bad_o);
      // R4
      rsvd_bits_chk: assert (!((ext_i[6:0] != '0) || (ext_i[8:7] == 2'b11)) || bad_o);
      // R5
      napot_off_chk: assert (!(!rwx_zero && ext_i[9] && !napot_en_i) || bad_o);
      // R6
      mtype_off_chk: assert (!(!rwx_zero && ext_i[8:7] != 2'b00 &&
                              !(mtype_en_i && mtype_on_i)) || bad_o);
      // R7
      ptr_attr_chk: assert (!(rwx_zero && (attr_i[7] || attr_i[6] || attr_i[4] ||
                             ext_i[9] || ext_i[8:7] != 2'b00)) || bad_o);
      // R8
      field_out_chk: assert (napot_o == ext_i[9] && mtype_o == ext_i[8:7]);
    end
  end
endmodule

bind pte_entry_classifier pte_entry_classifier_chk chk_i (
  .attr_i     (attr_i),
  .ext_i      (ext_i),
  .napot_en_i (napot_en_i),
  .mtype_en_i (mtype_en_i),
  .mtype_on_i (mtype_on_i),
  .bad_o      (bad_o),
  .ptr_o      (ptr_o),
  .leaf_o     (leaf_o),
  .napot_o    (napot_o),
  .mtype_o    (mtype_o)
);

// File: tb/pte_entry_classifier_tb_top.sv
module pte_entry_classifier_tb_top;
  logic       clk;
  logic       rst_n;
  logic [7:0] attr_i;
  logic [9:0] ext_i;
  logic       napot_en_i, mtype_en_i, mtype_on_i;
  logic       bad_o, ptr_o, leaf_o, napot_o;
  logic [1:0] mtype_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic [5:0] exp_q[$];
  string      tag_q[$];

  pte_entry_classifier dut_i (
    .attr_i(attr_i), .ext_i(ext_i),
    .napot_en_i(napot_en_i), .mtype_en_i(mtype_en_i), .mtype_on_i(mtype_on_i),
    .bad_o(bad_o), .ptr_o(ptr_o), .leaf_o(leaf_o),
    .napot_o(napot_o), .mtype_o(mtype_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // expected {bad, ptr, leaf, napot, mtype[1:0]} from the requirements
  function automatic logic [5:0] model(input logic [7:0] a, input logic [9:0] e,
                                       input logic ne, input logic me, input logic mo);
    logic shp_ptr, bad;
    shp_ptr = !a[1] && !a[2] && !a[3];
    bad = !a[0];                                          // R2
    if (a[2] && !a[1]) bad = 1'b1;                        // R3
    if (e[6:0] != 7'd0 || e[8:7] == 2'b11) bad = 1'b1;    // R4
    if (!shp_ptr && e[9] && !ne) bad = 1'b1;              // R5
    if (!shp_ptr && e[8:7] != 2'b00 && !(me && mo)) bad = 1'b1; // R6
    if (shp_ptr && (a[7] || a[6] || a[4] || e[9] || e[8:7] != 2'b00)) bad = 1'b1; // R7
    return {bad, !bad && shp_ptr, !bad && !shp_ptr, e[9], e[8:7]};
  endfunction

  task automatic drive(input logic [7:0] a, input logic [9:0] e,
                       input logic ne, input logic me, input logic mo, input string tag);
    @(posedge clk);
    #2;
    attr_i = a; ext_i = e; napot_en_i = ne; mtype_en_i = me; mtype_on_i = mo;
    exp_q.push_back(model(a, e, ne, me, mo));
    tag_q.push_back(tag);
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() != 0) begin
        logic [5:0] exp_v, act_v;
        string tg;
        exp_v = exp_q.pop_front();
        tg    = tag_q.pop_front();
        act_v = {bad_o, ptr_o, leaf_o, napot_o, mtype_o};
        n_tests++;
        if (act_v !== exp_v) begin
          n_fail++;
          $display("FAIL %s: got %b expected %b (attr=%h ext=%h en=%b%b%b)",
                   tg, act_v, exp_v, attr_i, ext_i, napot_en_i, mtype_en_i, mtype_on_i);
        end
      end
    end
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    attr_i = '0; ext_i = '0; napot_en_i = 0; mtype_en_i = 0; mtype_on_i = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // all-zero entry after reset: bad
    drive(8'h00, 10'h000, 0, 0, 0, "R2 zero entry");
    drive(8'h0E, 10'h000, 1, 1, 1, "R2 valid clear");
    drive(8'h01, 10'h000, 0, 0, 0, "R1 plain pointer");
    drive(8'h21, 10'h000, 0, 0, 0, "R7 global pointer");
    drive(8'h03, 10'h000, 0, 0, 0, "R1 read leaf");
    drive(8'h05, 10'h000, 1, 1, 1, "R3 write only");
    drive(8'h0D, 10'h000, 1, 1, 1, "R3 write exec");
    drive(8'h07, 10'h180, 1, 1, 1, "R4 mtype 3");
    for (int b = 0; b < 7; b++)
      drive(8'hCF, 10'(1 << b), 1, 1, 1, "R4 reserved bit");
    drive(8'h09, 10'h200, 0, 1, 1, "R5 napot disabled");
    drive(8'h09, 10'h200, 1, 0, 0, "R5 napot enabled");
    drive(8'h03, 10'h080, 1, 0, 1, "R6 mtype unsupported");
    drive(8'h03, 10'h100, 1, 1, 0, "R6 mtype switched off");
    drive(8'h03, 10'h100, 1, 1, 1, "R6 mtype allowed");
    drive(8'h81, 10'h000, 1, 1, 1, "R7 pointer dirty");
    drive(8'h41, 10'h000, 1, 1, 1, "R7 pointer accessed");
    drive(8'h11, 10'h000, 1, 1, 1, "R7 pointer user");
    drive(8'h01, 10'h200, 1, 1, 1, "R7 pointer napot");
    drive(8'h01, 10'h080, 1, 1, 1, "R7 pointer mtype");
    drive(8'h00, 10'h380, 0, 0, 0, "R8 fields on bad");
    for (int i = 0; i < 600; i++) begin
      logic [9:0] e;
      e = 10'($urandom);
      if (i % 2 == 0) e[6:0] = '0;
      drive(8'($urandom), e, 1'($urandom), 1'($urandom), 1'($urandom), "R1 random");
    end
    @(posedge clk);
    @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule